// File: doc/BRIEF.md
# High-Side Overcurrent Retry Regulator

This block supervises one high-side switch. It turns an enable request into a gate command. It watches a digital overcurrent comparator and decides when the switch has to back off. Each time the switch turns on, a fixed 40 µs blanking window masks the comparator, so that inrush current is not mistaken for a fault. After blanking, the comparator has to stay asserted for a selectable deglitch time before an overcurrent counts. When the supply-high flag is set, that time is forced to 10 µs.

With regulation enabled, a qualified overcurrent turns the switch off. The switch turns on again at the next boundary of a fixed retry period, whose origin is the moment of enable. This chops loads with large inrush current, such as lamps, at a steady rate, and a sticky status flag reports that chopping took place. With regulation disabled, which is the reset state, a qualified overcurrent shuts the switch down until the enable request is withdrawn and given again. All timing runs from a 1 µs tick, which a prescaler derives from the system clock.

Top module: `hs_retry_reg`

## Requirements
- R1: During and right after reset, `gate_on` and `reg_status` are 0.
- R2: `gate_on` rises on the first clock edge after `en_req` is seen high in idle. `oc_det` is ignored for the first 40 µs of every on-phase, so the shortest on-phase is 40 µs plus the deglitch time.
- R3: After blanking, `oc_det` must be high on every tick of the deglitch time before it qualifies. `dglt_sel` 2'b00/01/10/11 selects 48/40/32/24 µs. If `oc_det` is low on any tick, the count restarts from zero and `gate_on` stays high.
- R4: When `hv_supply` is 1, the deglitch time is 10 µs whatever the value of `dglt_sel`.
- R5: When `reg_en` is 1, a qualified overcurrent drops `gate_on`. `gate_on` rises again at the next retry-period boundary, counted from the enable, and blanking starts over. `freq_sel` 2'b00/01/10/11 gives periods of 588/455/333/227 µs.
- R6: When `reg_en` is 0, a qualified overcurrent drops `gate_on`, and it stays low for as long as `en_req` stays high.
- R7: `reg_status` sets on each qualified overcurrent while `reg_en` is 1 and holds until a `clr_pulse` cycle with no new trip. A clear that coincides with a trip leaves the flag set. A trip with `reg_en` at 0 does not set the flag.
- R8: `en_req` low drops `gate_on` on the next clock edge and returns the block to idle. `reg_status` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Switch enable request |
| oc_det | input | 1 | Overcurrent comparator output |
| hv_supply | input | 1 | Supply above high threshold; forces short deglitch |
| freq_sel | input | 2 | Retry period select |
| dglt_sel | input | 2 | Deglitch time select |
| reg_en | input | 1 | 1 = chop and retry, 0 = shut down on overcurrent |
| clr_pulse | input | 1 | Clears the status flag |
| gate_on | output | 1 | Gate command for the high-side switch |
| reg_status | output | 1 | Sticky flag: overcurrent regulation occurred |

## Verification
The assertions take all inputs as synchronous to `clk`. They also assume that `reg_en` and the select inputs change only between enable sessions, or at moments when a change of limit does not race a count in progress. The stimulus changes every input half a cycle away from the active edge. It changes `freq_sel` and `dglt_sel` only while the switch is idle or waiting for a period boundary. Comparator glitches are held for at least two ticks, so that a dropout is always seen on a tick.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BLANK = 3'd1,
    ST_ARMED = 3'd2,
    ST_OFFW  = 3'd3,
    ST_SHUT  = 3'd4
  } hsr_state_e;

endpackage

// File: rtl/hsr_tick.sv
module hsr_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/hsr_limits.sv
module hsr_limits #(
  parameter int TW     = 10,
  parameter int DG_HV  = 10,
  parameter int DG_MAX = 48,
  parameter int DG_STEP = 8,
  parameter int PER0   = 588,
  parameter int PER1   = 455,
  parameter int PER2   = 333,
  parameter int PER3   = 227
) (
  input  logic [1:0]    freq_sel,
  input  logic [1:0]    dglt_sel,
  input  logic          hv_supply,
  output logic [TW-1:0] dg_lim,
  output logic [TW-1:0] per_lim
);
  localparam int NSEL = 4;

  logic [TW-1:0] dg_tab  [NSEL];
  logic [TW-1:0] per_tab [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_dg
    assign dg_tab[i] = TW'(DG_MAX - DG_STEP * i);
  end

  assign per_tab[0] = TW'(PER0);
  assign per_tab[1] = TW'(PER1);
  assign per_tab[2] = TW'(PER2);
  assign per_tab[3] = TW'(PER3);

  always_comb begin
    dg_lim  = hv_supply ? TW'(DG_HV) : dg_tab[dglt_sel];
    per_lim = per_tab[freq_sel];
  end
endmodule

// File: rtl/hsr_core.sv
module hsr_core
  import hsr_pkg::*;
#(
  parameter int TW       = 10,
  parameter int BLANK_US = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_req,
  input  logic          oc_det,
  input  logic          reg_en,
  input  logic          clr_pulse,
  input  logic [TW-1:0] dg_lim,
  input  logic [TW-1:0] per_lim,
  output logic          gate_on,
  output logic          reg_status,
  output hsr_state_e    state
);
  localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_US - 1);

  hsr_state_e    st;
  logic [TW-1:0] ph_cnt;
  logic [TW-1:0] per_cnt;
  logic          active;
  logic          bnd;
  logic          trip;
  logic          stat_q;

  assign active = (st == ST_BLANK) || (st == ST_ARMED) || (st == ST_OFFW);
  assign bnd    = tick && (per_cnt >= per_lim - 1'b1);
  assign trip   = en_req && (st == ST_ARMED) && tick && oc_det
                  && (ph_cnt >= dg_lim - 1'b1);

  // Retry-period position, anchored at the enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (!active) begin
      per_cnt <= '0;
    end else if (tick) begin
      per_cnt <= bnd ? '0 : per_cnt + 1'b1;
    end
  end

  // Phase control: blanking, deglitch, off-wait, shutdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ph_cnt <= '0;
    end else if (!en_req) begin
      st     <= ST_IDLE;
      ph_cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st     <= ST_BLANK;
          ph_cnt <= '0;
        end
        ST_BLANK: begin
          if (tick) begin
            if (ph_cnt >= BLANK_LAST) begin
              st     <= ST_ARMED;
              ph_cnt <= '0;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
        end
        ST_ARMED: begin
          if (trip) begin
            st     <= reg_en ? ST_OFFW : ST_SHUT;
            ph_cnt <= '0;
          end else if (tick) begin
            ph_cnt <= oc_det ? ph_cnt + 1'b1 : '0;
          end
        end
        ST_OFFW: begin
          if (bnd) begin
            st     <= ST_BLANK;
            ph_cnt <= '0;
          end
        end
        ST_SHUT: st <= ST_SHUT;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Sticky regulation flag: a trip wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (trip && reg_en) begin
      stat_q <= 1'b1;
    end else if (clr_pulse) begin
      stat_q <= 1'b0;
    end
  end

  assign gate_on    = (st == ST_BLANK) || (st == ST_ARMED);
  assign reg_status = stat_q;
  assign state      = st;
endmodule

// File: rtl/hs_retry_reg.sv
module hs_retry_reg
  import hsr_pkg::*;
#(
  parameter int TICK_DIV = 250,
  parameter int BLANK_US = 40,
  parameter int DG_HV_US = 10,
  parameter int TW       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       oc_det,
  input  logic       hv_supply,
  input  logic [1:0] freq_sel,
  input  logic [1:0] dglt_sel,
  input  logic       reg_en,
  input  logic       clr_pulse,
  output logic       gate_on,
  output logic       reg_status
);
  logic          tick;
  logic [TW-1:0] dg_lim;
  logic [TW-1:0] per_lim;
  hsr_state_e    core_st;

  hsr_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  hsr_limits #(.TW(TW), .DG_HV(DG_HV_US)) u_lim (
    .freq_sel (freq_sel),
    .dglt_sel (dglt_sel),
    .hv_supply(hv_supply),
    .dg_lim   (dg_lim),
    .per_lim  (per_lim)
  );

  hsr_core #(.TW(TW), .BLANK_US(BLANK_US)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .en_req    (en_req),
    .oc_det    (oc_det),
    .reg_en    (reg_en),
    .clr_pulse (clr_pulse),
    .dg_lim    (dg_lim),
    .per_lim   (per_lim),
    .gate_on   (gate_on),
    .reg_status(reg_status),
    .state     (core_st)
  );
endmodule

// File: rtl/hsr_checker.sv
module hsr_checker
  import hsr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en_req,
  input logic       reg_en,
  input logic       clr_pulse,
  input logic       gate_on,
  input logic       reg_status,
  input hsr_state_e st
);
  AST_EN_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !gate_on); // R8

  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(en_req)); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_status && !clr_pulse) |=> reg_status); // R7

  AST_STATUS_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_status) |-> ($fell(gate_on) && $past(reg_en))); // R5

  AST_SHUT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHUT && en_req) |=> !gate_on); // R6

  AST_RESTART_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> ($past(st) == ST_IDLE || $past(st) == ST_OFFW)); // R5
endmodule

bind hs_retry_reg hsr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_req    (en_req),
  .reg_en    (reg_en),
  .clr_pulse (clr_pulse),
  .gate_on   (gate_on),
  .reg_status(reg_status),
  .st        (core_st)
);

// File: tb/sim_hs_retry_reg.sv
`timescale 1ns/1ps
module sim_hs_retry_reg;
  localparam int TDIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 1'b0, oc_det = 1'b0, hv_supply = 1'b0, reg_en = 1'b0, clr_pulse = 1'b0;
  logic [1:0] freq_sel = 2'b00, dglt_sel = 2'b00;
  logic gate_on, reg_status;

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  hs_retry_reg #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .oc_det(oc_det),
    .hv_supply(hv_supply), .freq_sel(freq_sel), .dglt_sel(dglt_sel),
    .reg_en(reg_en), .clr_pulse(clr_pulse),
    .gate_on(gate_on), .reg_status(reg_status));

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural reference: phase 0 idle, 1 masked-on, 2 watched-on, 3 waiting, 4 latched-off
  int  m_phase, m_on_us, m_streak, m_pos, m_edges;
  bit  m_flag;

  function automatic int period_us(input logic [1:0] s);
    int p[4] = '{588, 455, 333, 227};
    return p[s];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit tk, trip;
    int lim, plen;
    if (!rst_n) begin
      m_phase = 0; m_on_us = 0; m_streak = 0; m_pos = 0; m_edges = 0; m_flag = 0;
    end else begin
      tk = ((m_edges % TDIV) == TDIV - 1);
      m_edges++;
      lim = hv_supply ? 10 : 48 - 8 * int'(dglt_sel);
      plen = period_us(freq_sel);
      trip = 0;
      if (!en_req) begin
        m_phase = 0;
      end else begin
        bit wrapped;
        wrapped = 0;
        if (tk && m_phase >= 1 && m_phase <= 3) begin
          if (m_pos + 1 >= plen) begin m_pos = 0; wrapped = 1; end
          else m_pos++;
        end
        case (m_phase)
          0: begin m_phase = 1; m_on_us = 0; m_pos = 0; end
          1: if (tk) begin
               if (m_on_us + 1 >= 40) begin m_phase = 2; m_streak = 0; end
               else m_on_us++;
             end
          2: if (tk) begin
               if (oc_det) begin
                 if (m_streak + 1 >= lim) trip = 1;
                 else m_streak++;
               end else m_streak = 0;
               if (trip) m_phase = reg_en ? 3 : 4;
             end
          3: if (wrapped) begin m_phase = 1; m_on_us = 0; end
          default: ;
        endcase
      end
      if (trip && reg_en) m_flag = 1;
      else if (clr_pulse) m_flag = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input int tol, input string what);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison with the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, gate_on, (m_phase == 1 || m_phase == 2), "gate vs model");
      check(cur_req, reg_status, m_flag, "status vs model");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gate(input logic lvl, output int at);
    while (gate_on !== lvl) @(negedge clk);
    at = cyc;
  endtask

  // Watchdog
  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t_on, t_off, t_a, t_b, t_oc;
    step(5);
    check("R1", gate_on, 1'b0, "gate in reset");
    check("R1", reg_status, 1'b0, "status in reset");
    rst_n = 1'b1;
    step(3);
    check("R1", gate_on, 1'b0, "gate after reset");
    check("R1", reg_status, 1'b0, "status after reset");

    // R2 / R6: default mode, overcurrent from the start, 48 us deglitch
    cur_req = "R6";
    oc_det = 1; en_req = 1;
    step(1);
    check("R2", gate_on, 1'b1, "gate one edge after enable");
    t_on = cyc;
    wait_gate(1'b0, t_off);
    check_int("R2", t_off - t_on, (40 + 48) * TDIV, TDIV, "min on-time blank+deglitch cycles");
    step(600);
    check("R6", gate_on, 1'b0, "no restart with regulation off");
    check("R7", reg_status, 1'b0, "flag not set with regulation off");
    en_req = 0; oc_det = 0;
    step(4);

    // R3: glitches shorter than 24 us never trip
    cur_req = "R3";
    dglt_sel = 2'b11; en_req = 1;
    step(45 * TDIV);
    for (int i = 0; i < 4; i++) begin
      oc_det = 1; step(20 * TDIV);
      oc_det = 0; step(2 * TDIV);
    end
    check("R3", gate_on, 1'b1, "stays on through short overcurrent bursts");
    oc_det = 1; t_oc = cyc;
    wait_gate(1'b0, t_off);
    check_int("R3", t_off - t_oc, 24 * TDIV, TDIV + 1, "24 us deglitch cycles");
    en_req = 0; oc_det = 0;
    step(4);

    // R4: high supply forces 10 us
    cur_req = "R4";
    hv_supply = 1; dglt_sel = 2'b00; oc_det = 1; en_req = 1;
    step(1); t_on = cyc;
    wait_gate(1'b0, t_off);
    check_int("R4", t_off - t_on, (40 + 10) * TDIV, TDIV, "on-time with forced 10 us");
    en_req = 0; oc_det = 0; hv_supply = 0;
    step(4);

    // R5: regulation, 227 us period then 588 us
    cur_req = "R5";
    reg_en = 1; freq_sel = 2'b11; oc_det = 1; en_req = 1;
    wait_gate(1'b1, t_a);
    wait_gate(1'b0, t_off);
    check_int("R5", t_off - t_a, (40 + 48) * TDIV, TDIV, "regulated on-time");
    check("R7", reg_status, 1'b1, "flag set by regulated trip");
    wait_gate(1'b1, t_b);
    check_int("R5", t_b - t_a, 227 * TDIV, TDIV, "first restart after 227 us");
    wait_gate(1'b0, t_off);
    freq_sel = 2'b00;
    wait_gate(1'b1, t_a);
    wait_gate(1'b0, t_off);
    wait_gate(1'b1, t_b);
    check_int("R5", t_b - t_a, 588 * TDIV, 0, "restart spacing 588 us");

    // R7: clear in off-wait, then clear held across a trip
    cur_req = "R7";
    wait_gate(1'b0, t_off);
    clr_pulse = 1; step(1); clr_pulse = 0;
    check("R7", reg_status, 1'b0, "flag cleared");
    wait_gate(1'b1, t_a);
    clr_pulse = 1;
    wait_gate(1'b0, t_off);
    check("R7", reg_status, 1'b1, "trip wins over simultaneous clear");
    step(1);
    check("R7", reg_status, 1'b0, "held clear removes flag after trip");
    clr_pulse = 0;

    // R8: drop enable while on, flag preserved
    cur_req = "R8";
    wait_gate(1'b1, t_a);
    wait_gate(1'b0, t_off);
    wait_gate(1'b1, t_a);
    en_req = 0;
    step(1);
    check("R8", gate_on, 1'b0, "gate off one edge after enable drop");
    check("R8", reg_status, 1'b1, "flag kept on enable drop");
    step(300);
    check("R8", gate_on, 1'b0, "stays idle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule